// File: doc/BRIEF.md
# Multidrop-Capable Serial Transmitter

The block turns bytes written into a one-entry holding register into asynchronous serial frames on a single output line. Each frame has a low start bit, then the data bits with the least significant bit first, then an optional slot after the data, then a high stop bit. The line rests high between frames. Three mode inputs set the framing. A length field picks 5 to 8 data bits. A 2-bit slot field decides what goes into the slot after the data: a computed parity bit, a fixed level, nothing, or an address/data marker for multidrop links. A one-bit sense input feeds whichever slot option is selected.

Timing comes from a 16x baud enable supplied from outside, so every bit on the line lasts sixteen enabled clock cycles. The transmitter reads the mode inputs when it moves a byte from the holding register into the shifter. A new byte can therefore be accepted while the previous frame is still going out. The ready output tells the host when the holding register can take another byte.

Top module: `mdrop_uart_tx`

## Requirements
- R1: After reset, txd is high and tx_ready is high.
- R2: A frame is a start bit at 0, the data bits LSB first, the optional slot, and a stop bit at 1. Outside a frame txd stays at 1.
- R3: len_sel selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7, 2'b11 gives 8. Data bits above the selected length are not sent.
- R4: When par_mode is 2'b00, the slot holds a parity bit computed over the selected data bits only. par_type=0 gives even parity, so the data bits plus the slot hold an even number of ones. par_type=1 gives odd parity.
- R5: When par_mode is 2'b01, the slot is driven to the level of par_type, whatever the data.
- R6: When par_mode is 2'b10, there is no slot, and the stop bit follows the last data bit directly.
- R7: When par_mode is 2'b11, the slot carries par_type as a multidrop flag: 1 marks an address character and 0 marks a data character.
- R8: Each bit lasts exactly 16 cycles in which tick16 is high. txd does not change in a cycle that has no tick.
- R9: tx_ready is low while the holding register is full. A write (wr_en high) while tx_ready is low is ignored.
- R10: If the shifter is idle, a byte accepted on one clock edge moves into the shifter on the next edge, and txd goes low from that edge on. After a stop bit ends, a byte waiting in the holding register starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| len_sel | input | 2 | Data length select (5 to 8 bits) |
| par_mode | input | 2 | Slot mode: calc, forced, none, multidrop |
| par_type | input | 1 | Parity sense, forced level or address flag |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial data line, idles high |
| tx_ready | output | 1 | High when the holding register is empty |

## Verification
tx_ready falls on the same edge that takes a write. txd drops to the start level one edge later, when the shifter loads, and each following bit boundary falls on the sixteenth tick of the bit before it. The bench's reference model advances on the same edges as the design. It keeps a queue of pending line bits and a tick count, and both outputs are compared against it at every falling edge, half a cycle after the registers settle. The directed frame checks find the start bit and then sample each bit eight ticks into it, so a single-cycle timing slip shows up in the per-cycle comparison and not as a bit error.

// File: rtl/mdtx_pkg.sv
package mdtx_pkg;
   typedef enum logic [1:0] {
      SLOT_CALC  = 2'b00,
      SLOT_FIXED = 2'b01,
      SLOT_NONE  = 2'b10,
      SLOT_MDROP = 2'b11
   } slot_mode_e;
endpackage

// File: rtl/mdtx_frame_build.sv
module mdtx_frame_build #(
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2,
   localparam int DATA_W  = MIN_BITS + (1 << LEN_W) - 1,
   localparam int FRAME_W = DATA_W + 3,
   localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [LEN_W-1:0]   len_sel,
   input  logic [1:0]         par_mode,
   input  logic               par_type,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);
   import mdtx_pkg::*;

   logic [CNT_W-1:0]  ndata;
   logic [DATA_W-1:0] mask;
   logic              slot_en;
   logic              slot_val;
   slot_mode_e        mode;

   always_comb begin
      mode  = slot_mode_e'(par_mode);
      ndata = CNT_W'(MIN_BITS) + CNT_W'(len_sel);
      for (int i = 0; i < DATA_W; i++)
         mask[i] = (CNT_W'(i) < ndata);
      slot_en = (mode != SLOT_NONE);
      case (mode)
         SLOT_CALC: slot_val = (^(data & mask)) ^ par_type;
         default:   slot_val = par_type;
      endcase
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
         if (mask[i]) frame[i+1] = data[i];
      for (int i = 1; i < FRAME_W; i++)
         if (slot_en && CNT_W'(i) == ndata + CNT_W'(1)) frame[i] = slot_val;
      nbits = ndata + CNT_W'(2) + CNT_W'(slot_en);
   end
endmodule

// File: rtl/mdtx_bit_timer.sv
module mdtx_bit_timer #(
   parameter int TICKS   = 16,
   localparam int TCNT_W = $clog2(TICKS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic bit_end
);
   logic [TCNT_W-1:0] tcnt_q;
   localparam logic [TCNT_W-1:0] LAST = TCNT_W'(TICKS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         tcnt_q <= '0;
      else if (tick)
         tcnt_q <= (tcnt_q == LAST) ? '0 : tcnt_q + 1'b1;
   end

   assign bit_end = run && tick && (tcnt_q == LAST);
endmodule

// File: rtl/mdrop_uart_tx.sv
module mdrop_uart_tx #(
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2,
   parameter int TICKS    = 16,
   localparam int DATA_W  = MIN_BITS + (1 << LEN_W) - 1,
   localparam int FRAME_W = DATA_W + 3,
   localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic [LEN_W-1:0]  len_sel,
   input  logic [1:0]        par_mode,
   input  logic              par_type,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              tx_ready
);
   generate
      if (TICKS < 2 || (TICKS & (TICKS - 1)) != 0) begin : g_bad_ticks
         $error("TICKS must be a power of two of at least 2");
      end
      if (MIN_BITS < 1) begin : g_bad_min
         $error("MIN_BITS must be positive");
      end
   endgenerate

   logic [DATA_W-1:0]  hold_q;
   logic               hold_full_q;
   logic [FRAME_W-1:0] shift_q;
   logic [CNT_W-1:0]   left_q;
   logic               busy_q;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               bit_end;
   logic               load;

   mdtx_frame_build #(.MIN_BITS(MIN_BITS), .LEN_W(LEN_W)) u_build (
      .data     (hold_q),
      .len_sel  (len_sel),
      .par_mode (par_mode),
      .par_type (par_type),
      .frame    (frame),
      .nbits    (nbits)
   );

   mdtx_bit_timer #(.TICKS(TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_q),
      .tick    (tick16),
      .bit_end (bit_end)
   );

   assign load = hold_full_q && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_full_q <= 1'b0;
         hold_q      <= '0;
      end else if (wr_en && !hold_full_q) begin
         hold_full_q <= 1'b1;
         hold_q      <= wr_data;
      end else if (load) begin
         hold_full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         shift_q <= '1;
         left_q  <= '0;
      end else if (load) begin
         busy_q  <= 1'b1;
         shift_q <= frame;
         left_q  <= nbits - 1'b1;
      end else if (bit_end) begin
         if (left_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
            left_q  <= left_q - 1'b1;
         end
      end
   end

   assign txd      = busy_q ? shift_q[0] : 1'b1;
   assign tx_ready = !hold_full_q;
endmodule

// File: rtl/mdtx_chk.sv
module mdtx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick16,
   input logic wr_en,
   input logic tx_ready,
   input logic txd,
   input logic busy
);
   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);
   // R2
   stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd));
   // R8
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick16 |=> $stable(txd));
   // R9
   accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready && wr_en |=> !tx_ready);
   // R10
   start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !tx_ready |=> busy && !txd);
endmodule

bind mdrop_uart_tx mdtx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick16   (tick16),
   .wr_en    (wr_en),
   .tx_ready (tx_ready),
   .txd      (txd),
   .busy     (busy_q)
);

// File: tb/mdrop_uart_tx_bench.sv
module mdrop_uart_tx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic [1:0] len_sel = 2'b11;
   logic [1:0] par_mode = 2'b00;
   logic       par_type = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd;
   logic       tx_ready;

   int  n_checks = 0;
   int  n_fails  = 0;
   int  cyc      = 0;
   bit  done     = 0;
   int  tick_div = 1;
   bit  tick_off = 0;

   mdrop_uart_tx u_mdrop_uart_tx (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .len_sel(len_sel),
      .par_mode(par_mode), .par_type(par_type), .wr_en(wr_en),
      .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   // expected line bits, index 0 is the start bit
   task automatic exp_frame(input logic [7:0] d, input logic [1:0] len, input logic [1:0] pm,
                            input logic typ, output logic [11:0] v, output int nb);
      int nd = 5 + int'(len);
      int ones = 0;
      v = '1;
      v[0] = 1'b0;
      for (int i = 0; i < nd; i++) begin
         v[i+1] = d[i];
         if (d[i]) ones++;
      end
      nb = nd + 1;
      if (pm == 2'b00) begin
         v[nb] = typ ? ~ones[0] : ones[0];
         nb++;
      end else if (pm != 2'b10) begin
         v[nb] = typ;
         nb++;
      end
      v[nb] = 1'b1;
      nb++;
   endtask

   // behavioural reference model
   bit   m_q[$];
   int   m_tk;
   bit   m_hv;
   logic [7:0] m_hd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_tk = 0;
         m_hv = 0;
         m_hd = 8'h00;
      end else begin
         automatic bit old_hv = m_hv;
         automatic bit old_busy = (m_q.size() > 0);
         if (old_busy) begin
            if (tick16) begin
               if (m_tk == 15) begin
                  m_tk = 0;
                  void'(m_q.pop_front());
               end else m_tk++;
            end
         end else if (old_hv) begin
            automatic logic [11:0] v;
            automatic int nb;
            exp_frame(m_hd, len_sel, par_mode, par_type, v, nb);
            for (int i = 0; i < nb; i++) m_q.push_back(v[i]);
            m_tk = 0;
            m_hv = 0;
         end
         if (wr_en && !old_hv) begin
            m_hv = 1;
            m_hd = wr_data;
         end
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (tick_off) tick16 <= 1'b0;
      else tick16 <= (cyc % tick_div == 0);
      if (rst_n && !done) begin
         check("R8", int'(txd), (m_q.size() > 0) ? int'(m_q[0]) : 1);
         check("R9", int'(tx_ready), int'(!m_hv));
      end
      if (cyc >= WATCHDOG) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   task automatic write_byte(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic capture(input int nb, output logic [11:0] got);
      int guard = 0;
      got = '1;
      while (txd !== 1'b0 && guard < 3000) begin
         @(negedge clk);
         guard++;
      end
      repeat (8) @(negedge clk);
      got[0] = txd;
      for (int k = 1; k < nb; k++) begin
         repeat (16) @(negedge clk);
         got[k] = txd;
      end
   endtask

   task automatic frame_test(input string req, input logic [7:0] d, input logic [1:0] len,
                             input logic [1:0] pm, input logic typ);
      logic [11:0] v, got;
      int nb;
      @(negedge clk);
      len_sel = len;
      par_mode = pm;
      par_type = typ;
      exp_frame(d, len, pm, typ, v, nb);
      write_byte(d);
      capture(nb, got);
      check(req, int'(got), int'(v));
      repeat (12) @(negedge clk);
   endtask

   initial begin
      logic [11:0] v, got;
      int nb;
      logic held;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", int'(txd), 1);
      check("R1", int'(tx_ready), 1);

      frame_test("R4 even", 8'hA5, 2'b11, 2'b00, 1'b0);
      frame_test("R4 odd",  8'hA5, 2'b11, 2'b00, 1'b1);
      // R3 upper bits dropped, R4 parity over 5 bits only (10011 -> 3 ones)
      frame_test("R3 R4 five-bit", 8'hF3, 2'b00, 2'b00, 1'b0);
      frame_test("R5 forced 1 six-bit R3", 8'h3C, 2'b01, 2'b01, 1'b1);
      frame_test("R5 forced 0", 8'h3D, 2'b01, 2'b01, 1'b0);
      frame_test("R6 no slot seven-bit R3", 8'h55, 2'b10, 2'b10, 1'b0);
      frame_test("R7 address", 8'h81, 2'b11, 2'b11, 1'b1);
      frame_test("R7 data", 8'h81, 2'b11, 2'b11, 1'b0);
      // R2 idle line
      check("R2", int'(txd), 1);

      // R9 / R10 back-to-back with an ignored write
      len_sel = 2'b11; par_mode = 2'b10; par_type = 1'b0;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h4B;
      @(negedge clk);
      check("R9", int'(tx_ready), 0);
      wr_data = 8'hE7;
      @(negedge clk);
      wr_en = 1'b0;
      check("R10", int'(txd), 0);
      check("R9", int'(tx_ready), 1);
      write_byte(8'h2D);
      exp_frame(8'h4B, 2'b11, 2'b10, 1'b0, v, nb);
      capture(nb, got);
      check("R10 first", int'(got), int'(v));
      exp_frame(8'h2D, 2'b11, 2'b10, 1'b0, v, nb);
      capture(nb, got);
      check("R9 ignored write", int'(got), int'(v));
      repeat (12) @(negedge clk);
      check("R2", int'(txd), 1);

      // R8 sparse ticks and a hold with no ticks
      tick_div = 3;
      par_mode = 2'b00;
      write_byte(8'h96);
      repeat (100) @(negedge clk);
      tick_off = 1;
      @(negedge clk);
      @(negedge clk);
      held = txd;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check("R8 hold", int'(txd), int'(held));
      end
      tick_off = 0;
      repeat (700) @(negedge clk);
      check("R2", int'(txd), 1);
      check("R9", int'(tx_ready), 1);
      finish_run();
   end
endmodule